// File: doc/BRIEF.md
# SRAM Write-Window Timing Monitor

This block observes the control, address and data lines of an asynchronous static RAM bus from a clock domain that runs much faster than the bus itself. It works out when a write is in progress and times each write in sample ticks. It then checks those times against the minimum write timing of the memory's speed grade.

A write is in progress only while three controls are active together: an active-low select, an active-high select and an active-low write strobe. The window opens on whichever of the three becomes active last. It closes on whichever becomes inactive first.

For every window the monitor measures four intervals:
- the window length;
- how long both selects had been active;
- how long the address had been steady;
- how long the data had been steady.

Each measured interval is compared with a threshold. The threshold is the nanosecond limit divided by the sample period, rounded up. Any shortfall sets a sticky flag for that rule. Address or data movement in the sample where the window opens or closes, or inside an open window, sets further flags. A software-visible clear input wipes all flags.

A window counter, the last measured width and the signal that closed the last window are also reported.

Top module: `wwin_monitor`

## Requirements
- R1: A write window is the run of samples in which `sel_n_in` is 0, `sel_in` is 1 and `wr_n_in` is 0. When a window closes, `win_count` rises by exactly one and `last_width` becomes the window length in samples.
- R2: `viol[0]` is set when the window length is below ceil(40/SAMPLE_NS) samples with `slow_grade`=0, or below ceil(50/SAMPLE_NS) with `slow_grade`=1.
- R3: `viol[1]` is set when, at the close, the number of samples during which both selects had been active is below ceil(45/SAMPLE_NS) (grade 0) or ceil(60/SAMPLE_NS) (grade 1).
- R4: `viol[2]` is set when the address changes in the same sample in which the window opens. The setup minimum is zero, so only coincidence fails.
- R5: `viol[3]` is set when the number of samples from the last address change to the close is below ceil(45/SAMPLE_NS) (grade 0) or ceil(60/SAMPLE_NS) (grade 1).
- R6: `viol[4]` is set when the data has been steady for fewer than ceil(25/SAMPLE_NS) (grade 0) or ceil(30/SAMPLE_NS) (grade 1) samples before the close.
- R7: `viol[5]` is set when the data changes in the sample in which the window closes.
- R8: An address change in the closing sample sets `viol[6]` if the window was closed by `sel_n_in` or `wr_n_in` rising, and sets `viol[7]` if it was closed by `sel_in` falling. `last_cause` reports the closing signal as 0 for `sel_n_in`, 1 for `wr_n_in` and 2 for `sel_in`.
- R9: `viol[8]` is set when the address changes in a sample in which the window was already open in the previous sample and is still open.
- R10: Flags are sticky. A flag stays set until `clr` is 1 at a clock edge, which leaves every flag at 0 in the following cycle.
- R11: After reset, `viol`, `win_count`, `last_width` and `last_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all violation flags |
| slow_grade | input | 1 | 0 selects the faster speed grade limits, 1 the slower |
| sel_n_in | input | 1 | Active-low chip select from the memory bus |
| sel_in | input | 1 | Active-high chip select from the memory bus |
| wr_n_in | input | 1 | Active-low write strobe from the memory bus |
| addr_in | input | ADDR_W | Memory address bus |
| data_in | input | DATA_W | Memory data bus |
| viol | output | 9 | Sticky per-rule violation flags |
| win_count | output | CNT_W | Number of write windows closed since reset |
| last_width | output | CNT_W | Length in samples of the last closed window |
| last_cause | output | 2 | Signal that closed the last window |

## Verification
The bench builds the monitor with its defaults: SAMPLE_NS=8, CNT_W=16, a 17-bit address and an 8-bit data bus. The rounded limits are therefore 5/7 samples for width, 6/8 for select and address-to-close, and 4/4 for data setup. Because the limits are only a few samples long, every rule can be driven one sample under and exactly at its limit, in both grades. Windows closed by each of the three controls, and randomly composed windows, are then compared flag by flag with a model in the bench.

// File: rtl/wwin_pkg.sv
package wwin_pkg;

    // Rule flag positions
    localparam int NRULES = 9;
    localparam int RB_PW  = 0;  // window too short
    localparam int RB_SE  = 1;  // select-to-close too short
    localparam int RB_AS  = 2;  // address moved as window opened
    localparam int RB_AE  = 3;  // address-to-close too short
    localparam int RB_DS  = 4;  // data setup too short
    localparam int RB_DH  = 5;  // data moved as window closed
    localparam int RB_RC1 = 6;  // address moved at close by low select / strobe
    localparam int RB_RC2 = 7;  // address moved at close by high select
    localparam int RB_AMW = 8;  // address moved inside open window

    typedef enum logic [1:0] {
        END_SELN = 2'd0,
        END_WRN  = 2'd1,
        END_SEL  = 2'd2
    } end_cause_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic wr_n;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1};

    typedef struct packed {
        logic       opened;
        logic       closed;
        logic       in_win;
        logic       addr_mv;
        logic       data_mv;
        end_cause_e cause;
    } evt_t;

    typedef enum logic [1:0] {
        LIM_PW,
        LIM_SE,
        LIM_AE,
        LIM_DS
    } lim_e;

    // Nanosecond minimum of a rule for the chosen grade
    function automatic int lim_ns(input lim_e which, input logic slow);
        int v;
        case (which)
            LIM_PW:  v = slow ? 50 : 40;
            LIM_SE:  v = slow ? 60 : 45;
            LIM_AE:  v = slow ? 60 : 45;
            default: v = slow ? 30 : 25;
        endcase
        return v;
    endfunction

    function automatic int ceil_div(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

endpackage

// File: rtl/wwin_sync.sv
module wwin_sync #(
    parameter int           W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST;
            q      <= RST;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/wwin_track.sv
module wwin_track
    import wwin_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output evt_t              evt,
    output logic [CNT_W-1:0]  win_ticks,
    output logic [CNT_W-1:0]  sel_ticks,
    output logic [CNT_W-1:0]  addr_ticks,
    output logic [CNT_W-1:0]  data_ticks
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    ctl_t              ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    logic open_now, open_q, chosen_now, chosen_q;

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
        return (v == CMAX) ? v : v + 1'b1;
    endfunction

    always_comb begin
        open_now   = !ctl.sel_n && ctl.sel && !ctl.wr_n;
        open_q     = !ctl_q.sel_n && ctl_q.sel && !ctl_q.wr_n;
        chosen_now = !ctl.sel_n && ctl.sel;
        chosen_q   = !ctl_q.sel_n && ctl_q.sel;

        evt.opened  = open_now && !open_q;
        evt.closed  = !open_now && open_q;
        evt.in_win  = open_now && open_q;
        evt.addr_mv = (addr != addr_q);
        evt.data_mv = (data != data_q);

        // several may deassert together: low select, then strobe, then high select
        if (ctl.sel_n && !ctl_q.sel_n)
            evt.cause = END_SELN;
        else if (ctl.wr_n && !ctl_q.wr_n)
            evt.cause = END_WRN;
        else
            evt.cause = END_SEL;
    end

    // Counters hold the number of samples before the current one
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= CTL_IDLE;
            addr_q     <= '0;
            data_q     <= '0;
            win_ticks  <= '0;
            sel_ticks  <= '0;
            addr_ticks <= CMAX;
            data_ticks <= CMAX;
        end else begin
            ctl_q  <= ctl;
            addr_q <= addr;
            data_q <= data;

            if (evt.opened)
                win_ticks <= CNT_W'(1);
            else if (open_now)
                win_ticks <= bump(win_ticks);
            else
                win_ticks <= '0;

            if (chosen_now && !chosen_q)
                sel_ticks <= CNT_W'(1);
            else if (chosen_now)
                sel_ticks <= bump(sel_ticks);
            else
                sel_ticks <= '0;

            addr_ticks <= evt.addr_mv ? CNT_W'(1) : bump(addr_ticks);
            data_ticks <= evt.data_mv ? CNT_W'(1) : bump(data_ticks);
        end
    end

    AST_SEL_COVERS_WIN: assert property (@(posedge clk) disable iff (rst)
        evt.closed |-> (sel_ticks >= win_ticks)); // R3

    AST_OPEN_NEEDS_IDLE_BEFORE: assert property (@(posedge clk) disable iff (rst)
        evt.opened |=> (win_ticks == CNT_W'(1))); // R1

endmodule

// File: rtl/wwin_rules.sv
module wwin_rules
    import wwin_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SAMPLE_NS = 8
) (
    input  logic              slow,
    input  evt_t              evt,
    input  logic [CNT_W-1:0]  win_ticks,
    input  logic [CNT_W-1:0]  sel_ticks,
    input  logic [CNT_W-1:0]  addr_ticks,
    input  logic [CNT_W-1:0]  data_ticks,
    output logic [CNT_W-1:0]  pw_lim,
    output logic [NRULES-1:0] hit
);
    localparam logic [CNT_W-1:0] PW_F = CNT_W'(ceil_div(lim_ns(LIM_PW, 1'b0), SAMPLE_NS));
    localparam logic [CNT_W-1:0] PW_S = CNT_W'(ceil_div(lim_ns(LIM_PW, 1'b1), SAMPLE_NS));
    localparam logic [CNT_W-1:0] SE_F = CNT_W'(ceil_div(lim_ns(LIM_SE, 1'b0), SAMPLE_NS));
    localparam logic [CNT_W-1:0] SE_S = CNT_W'(ceil_div(lim_ns(LIM_SE, 1'b1), SAMPLE_NS));
    localparam logic [CNT_W-1:0] AE_F = CNT_W'(ceil_div(lim_ns(LIM_AE, 1'b0), SAMPLE_NS));
    localparam logic [CNT_W-1:0] AE_S = CNT_W'(ceil_div(lim_ns(LIM_AE, 1'b1), SAMPLE_NS));
    localparam logic [CNT_W-1:0] DS_F = CNT_W'(ceil_div(lim_ns(LIM_DS, 1'b0), SAMPLE_NS));
    localparam logic [CNT_W-1:0] DS_S = CNT_W'(ceil_div(lim_ns(LIM_DS, 1'b1), SAMPLE_NS));

    logic [CNT_W-1:0] se_lim, ae_lim, ds_lim;

    always_comb begin
        pw_lim = slow ? PW_S : PW_F;
        se_lim = slow ? SE_S : SE_F;
        ae_lim = slow ? AE_S : AE_F;
        ds_lim = slow ? DS_S : DS_F;

        hit         = '0;
        hit[RB_PW]  = evt.closed && (win_ticks < pw_lim);
        hit[RB_SE]  = evt.closed && (sel_ticks < se_lim);
        hit[RB_AS]  = evt.opened && evt.addr_mv;
        hit[RB_AE]  = evt.closed && (addr_ticks < ae_lim);
        hit[RB_DS]  = evt.closed && (data_ticks < ds_lim);
        hit[RB_DH]  = evt.closed && evt.data_mv;
        hit[RB_RC1] = evt.closed && evt.addr_mv && (evt.cause != END_SEL);
        hit[RB_RC2] = evt.closed && evt.addr_mv && (evt.cause == END_SEL);
        hit[RB_AMW] = evt.in_win && evt.addr_mv;
    end

    always_comb begin
        AST_ONE_RECOVERY_CASE: assert ($countones(hit[RB_RC2:RB_RC1]) <= 1); // R8
    end

endmodule

// File: rtl/wwin_monitor.sv
module wwin_monitor
    import wwin_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 16,
    parameter int SAMPLE_NS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              slow_grade,
    input  logic              sel_n_in,
    input  logic              sel_in,
    input  logic              wr_n_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [NRULES-1:0] viol,
    output logic [CNT_W-1:0]  win_count,
    output logic [CNT_W-1:0]  last_width,
    output logic [1:0]        last_cause
);
    ctl_t              ctl_raw, ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    evt_t              evt;
    logic [CNT_W-1:0]  win_ticks, sel_ticks, addr_ticks, data_ticks, pw_lim;
    logic [NRULES-1:0] hit;

    assign ctl_raw = '{sel_n: sel_n_in, sel: sel_in, wr_n: wr_n_in};

    wwin_sync #(.W($bits(ctl_t)), .RST(CTL_IDLE)) u_sync_ctl (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
    );
    wwin_sync #(.W(ADDR_W), .RST('0)) u_sync_addr (
        .clk(clk), .rst(rst), .d(addr_in), .q(addr_s)
    );
    wwin_sync #(.W(DATA_W), .RST('0)) u_sync_data (
        .clk(clk), .rst(rst), .d(data_in), .q(data_s)
    );

    wwin_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst(rst), .ctl(ctl_s), .addr(addr_s), .data(data_s),
        .evt(evt), .win_ticks(win_ticks), .sel_ticks(sel_ticks),
        .addr_ticks(addr_ticks), .data_ticks(data_ticks)
    );

    wwin_rules #(.CNT_W(CNT_W), .SAMPLE_NS(SAMPLE_NS)) u_rules (
        .slow(slow_grade), .evt(evt), .win_ticks(win_ticks), .sel_ticks(sel_ticks),
        .addr_ticks(addr_ticks), .data_ticks(data_ticks), .pw_lim(pw_lim), .hit(hit)
    );

    // Sticky flags, clear has priority over a new hit
    for (genvar r = 0; r < NRULES; r++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst || clr)
                flag_q <= 1'b0;
            else if (hit[r])
                flag_q <= 1'b1;
        end
        assign viol[r] = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_count  <= '0;
            last_width <= '0;
            last_cause <= 2'd0;
        end else if (evt.closed) begin
            win_count  <= win_count + 1'b1;
            last_width <= win_ticks;
            last_cause <= evt.cause;
        end
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (viol == '0)); // R10

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((viol & $past(viol)) == $past(viol))); // R10

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (win_count != $past(win_count)) |-> (win_count == $past(win_count) + 1'b1)); // R1

    AST_SHORT_WIDTH_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        ((win_count != $past(win_count)) && (last_width < $past(pw_lim))) |-> viol[RB_PW]); // R2

endmodule

// File: tb/test_wwin_monitor.sv
module test_wwin_monitor;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int CW = 16;
    localparam int PER = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          slow_grade = 1'b0;
    logic          sel_n_in = 1'b1;
    logic          sel_in = 1'b0;
    logic          wr_n_in = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic [8:0]    viol;
    logic [CW-1:0] win_count;
    logic [CW-1:0] last_width;
    logic [1:0]    last_cause;

    int checks = 0;
    int fails  = 0;
    int wins   = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wwin_monitor #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .SAMPLE_NS(PER)) i_wwin_monitor (
        .clk(clk), .rst(rst), .clr(clr), .slow_grade(slow_grade),
        .sel_n_in(sel_n_in), .sel_in(sel_in), .wr_n_in(wr_n_in),
        .addr_in(addr_in), .data_in(data_in),
        .viol(viol), .win_count(win_count), .last_width(last_width), .last_cause(last_cause)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int tk(input int ns);
        return (ns + PER - 1) / PER;
    endfunction

    // Bench model of the flag vector for one window
    function automatic logic [8:0] model(input int cause, input int lead, input int w, input int ds,
                                         input int apre, input int rec, input bit hold_bad,
                                         input bit glitch, input bit slow);
        logic [8:0] f = '0;
        int t_pw = tk(slow ? 50 : 40);
        int t_se = tk(slow ? 60 : 45);
        int t_ae = tk(slow ? 60 : 45);
        int t_ds = tk(slow ? 30 : 25);
        int since_addr = glitch ? w - 1 : w + apre;
        f[0] = (w < t_pw);                  // R2
        f[1] = ((w + lead) < t_se);         // R3
        f[2] = (apre == 0);                 // R4
        f[3] = (since_addr < t_ae);         // R5
        f[4] = (ds < t_ds);                 // R6
        f[5] = hold_bad;                    // R7
        f[6] = (rec == 0) && (cause != 2);  // R8
        f[7] = (rec == 0) && (cause == 2);  // R8
        f[8] = glitch;                      // R9
        return f;
    endfunction

    task automatic run_win(input int cause, input int lead, input int w, input int ds,
                           input int apre, input int rec, input bit hold_bad,
                           input bit glitch, input bit slow);
        int s = 12;
        int e = s + w;
        int sel_t = (lead > 0) ? s - lead : s;
        bit lastsel = 1'($urandom % 2);
        int csn_on = lastsel ? sel_t : sel_t - 1;
        int cs2_on = lastsel ? sel_t - 1 : sel_t;
        int we_on = (lead > 0) ? s : s - 2;
        int csn_off = (cause == 0) ? e : e + 2;
        int we_off  = (cause == 1) ? e : e + 2;
        int cs2_off = (cause == 2) ? e : e + 2;
        logic [8:0] expf;
        slow_grade = slow;
        for (int t = 0; t <= e + 8; t++) begin
            sel_n_in = !(t >= csn_on && t < csn_off);
            sel_in   = (t >= cs2_on && t < cs2_off);
            wr_n_in  = !(t >= we_on && t < we_off);
            if (t == s - apre) addr_in = addr_in ^ AW'(($urandom % ((1 << AW) - 1)) + 1);
            if (glitch && t == s + 1) addr_in = addr_in ^ AW'(($urandom % ((1 << AW) - 1)) + 1);
            if (t == e + rec) addr_in = addr_in ^ AW'(($urandom % ((1 << AW) - 1)) + 1);
            if (t == e - ds) data_in = data_in ^ DW'(($urandom % 255) + 1);
            if (hold_bad && t == e) data_in = data_in ^ DW'(($urandom % 255) + 1);
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        wins++;
        expf = model(cause, lead, w, ds, apre, rec, hold_bad, glitch, slow);
        chk(viol == expf, "R2-flags R3 R4 R5 R6 R7 R8 R9 flag vector", viol, expf);
        chk(win_count == CW'(wins), "R1 window count", win_count, wins);
        chk(last_width == CW'(w), "R1 width", last_width, w);
        chk(last_cause == 2'(cause), "R8 closing cause", last_cause, cause);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(viol == 9'd0, "R10 clear", viol, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(viol == 9'd0, "R11 reset flags", viol, 0);
        chk(win_count == '0, "R11 reset count", win_count, 0);
        chk(last_width == '0, "R11 reset width", last_width, 0);
        chk(last_cause == 2'd0, "R11 reset cause", last_cause, 0);

        for (int g = 0; g < 2; g++) begin
            bit sl = 1'(g);
            int t_pw = tk(sl ? 50 : 40);
            int t_se = tk(sl ? 60 : 45);
            int t_ae = tk(sl ? 60 : 45);
            int t_ds = tk(sl ? 30 : 25);
            // R2 width boundary
            run_win(1, 8, t_pw - 1, 12, 10, 2, 0, 0, sl);
            run_win(1, 8, t_pw, 12, 10, 2, 0, 0, sl);
            // R3 select boundary
            run_win(0, t_se - t_pw - 1, t_pw, 12, 10, 2, 0, 0, sl);
            run_win(0, t_se - t_pw, t_pw, 12, 10, 2, 0, 0, sl);
            // R5 and R4 address-to-close boundary
            run_win(1, 8, t_pw, 12, t_ae - t_pw - 1, 2, 0, 0, sl);
            run_win(1, 8, t_pw, 12, t_ae - t_pw, 2, 0, 0, sl);
            // R6 data setup boundary
            run_win(2, 8, 10, t_ds - 1, 10, 2, 0, 0, sl);
            run_win(2, 8, 10, t_ds, 10, 2, 0, 0, sl);
            // R7 data hold
            run_win(1, 8, 10, 6, 10, 2, 1, 0, sl);
            // R8 recovery per closing signal, just at and just past the limit
            for (int c = 0; c < 3; c++) begin
                run_win(c, 8, 10, 6, 10, 0, 0, 0, sl);
                run_win(c, 8, 10, 6, 10, 1, 0, 0, sl);
            end
            // R9 address moves inside open window
            run_win(0, 8, 10, 6, 10, 2, 0, 1, sl);
        end

        for (int n = 0; n < 150; n++) begin
            int  w  = 1 + int'($urandom % 12);
            bit  gl = (w >= 3) && ($urandom % 5 == 0);
            run_win(int'($urandom % 3), int'($urandom % 9), w, 1 + int'($urandom % (w + 11)),
                    int'($urandom % 11), int'($urandom % 4), 1'($urandom % 6 == 0), gl,
                    1'($urandom % 2));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule